// File: doc/BRIEF.md
# Dual-Mode Link Mode Controller

This block owns the operating mode of a configuration memory that can either stream its contents one way, clocked by a dedicated stream clock, or act as a slave on a two-wire bidirectional bus. After power-up reset it is in streaming mode. A falling edge on the bus clock stops the stream and opens a transition window. During this window the bus slave looks for its address, and the block counts stream-clock pulses that arrive while the bus clock rests high.

The window ends in one of two ways. If the slave reports an address match, the block locks into bidirectional mode, and only a new power-up reset ends it. If instead the required number of idle stream-clock pulses arrives first (128 by default) with no further bus clock fall, the block returns to streaming. It also raises a one-cycle restart strobe so the streamer starts again from the most significant bit of address 00h. While in bidirectional mode the stream-clock level serves only as a write-enable qualifier.

Both clock inputs arrive as already filtered, synchronous levels. The address match arrives as a single-cycle pulse from the bus decoder.

Top module: `mdx_mode_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, mode_o is 2'b00 (streaming), stream_en_o is 1, and slave_en_o, stream_restart_o and wr_en_o are 0.
- R2: A bus clock fall (high on one clock edge, low on the next) seen in streaming mode makes mode_o 2'b01 (transition) on the next cycle, with stream_en_o 0 (stream output released) and slave_en_o 1.
- R3: In transition mode, a stream-clock rising edge counts only while the bus clock is high. The cycle after the count reaches RECOVER_PULSES (128), mode_o returns to 2'b00 and stream_en_o to 1.
- R4: stream_restart_o is high for exactly one cycle, in the same cycle that a return from transition to streaming becomes visible, and at no other time.
- R5: Any bus clock fall during transition mode clears the pulse count, so RECOVER_PULSES fresh idle pulses are needed after it.
- R6: Stream-clock rising edges that occur while the bus clock is low are not counted toward recovery.
- R7: An address-match pulse in transition mode makes mode_o 2'b10 (bidirectional) on the next cycle. It wins over a simultaneous bus clock fall and over a full count.
- R8: Bidirectional mode is left only by reset. Bus clock falls, any number of stream-clock pulses and further match pulses leave mode_o at 2'b10.
- R9: An address-match pulse in streaming mode is ignored: mode_o stays 2'b00 and slave_en_o stays 0.
- R10: wr_en_o equals the stream-clock level sampled one cycle earlier while in bidirectional mode, and is 0 in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| bus_clk_i | input | 1 | Filtered bus clock level |
| strm_clk_i | input | 1 | Filtered stream clock level |
| addr_hit_i | input | 1 | Single-cycle pulse from the bus decoder on a matching address byte |
| mode_o | output | 2 | 00 streaming, 01 transition, 10 bidirectional |
| stream_en_o | output | 1 | Streamer may drive the data line |
| stream_restart_o | output | 1 | One-cycle strobe: restart the stream at address 00h, MSB |
| slave_en_o | output | 1 | Bus slave is active |
| wr_en_o | output | 1 | Array writes allowed by the stream-clock level |

## Verification
Mode, enables and write-enable are due one clock edge after the input change that causes them, because edge detection and the mode decision share one register stage. Recovery is due two edges after the input change that carries the final stream-clock pulse: one edge to reach the full count and one to act on it. The bench drives inputs on the falling clock edge and samples on the next falling edge, which places each sample after the edge where the result is due. A behavioural model advanced on every rising edge is compared against all outputs on every cycle. Directed checks pin the exact cycles around each mode change.

// File: rtl/mdx_pkg.sv
package mdx_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_TRANS  = 2'b01,
    MODE_BIDIR  = 2'b10
  } mode_e;
endpackage

// File: rtl/mdx_edge.sv
// Registered edge detector for N synchronous level inputs.
module mdx_edge #(
  parameter int   N       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= RST_VAL;
      else     prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = ~prev_q[g] &  lvl_i[g];
    assign fall_o[g] =  prev_q[g] & ~lvl_i[g];
  end
endmodule

// File: rtl/mdx_pulse_cnt.sv
// Saturating pulse counter with synchronous clear.
module mdx_pulse_cnt #(
  parameter int LIMIT = 128,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == LIM_V);
endmodule

// File: rtl/mdx_mode_fsm.sv
// Mode decision with registered outputs.
module mdx_mode_fsm
  import mdx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bus_fall_i,
  input  logic  hit_i,
  input  logic  full_i,
  input  logic  strm_lvl_i,
  output mode_e mode_o,
  output logic  in_trans_o,
  output logic  stream_en_o,
  output logic  slave_en_o,
  output logic  restart_o,
  output logic  wr_en_o
);
  mode_e st_q, st_nx;
  logic  rs_nx;
  logic  sen_q, slv_q, rs_q, wr_q;

  always_comb begin
    st_nx = st_q;
    rs_nx = 1'b0;
    unique case (st_q)
      MODE_STREAM: if (bus_fall_i) st_nx = MODE_TRANS;
      MODE_TRANS: begin
        if (hit_i)           st_nx = MODE_BIDIR;
        else if (bus_fall_i) st_nx = MODE_TRANS;
        else if (full_i) begin
          st_nx = MODE_STREAM;
          rs_nx = 1'b1;
        end
      end
      MODE_BIDIR:  st_nx = MODE_BIDIR;
      default:     st_nx = MODE_STREAM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= MODE_STREAM;
      sen_q <= 1'b1;
      slv_q <= 1'b0;
      rs_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_nx;
      sen_q <= (st_nx == MODE_STREAM);
      slv_q <= (st_nx != MODE_STREAM);
      rs_q  <= rs_nx;
      wr_q  <= (st_nx == MODE_BIDIR) && strm_lvl_i;
    end
  end

  assign mode_o      = st_q;
  assign in_trans_o  = (st_q == MODE_TRANS);
  assign stream_en_o = sen_q;
  assign slave_en_o  = slv_q;
  assign restart_o   = rs_q;
  assign wr_en_o     = wr_q;
endmodule

// File: rtl/mdx_mode_ctrl.sv
module mdx_mode_ctrl
  import mdx_pkg::*;
#(
  parameter int RECOVER_PULSES = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_clk_i,
  input  logic       strm_clk_i,
  input  logic       addr_hit_i,
  output logic [1:0] mode_o,
  output logic       stream_en_o,
  output logic       stream_restart_o,
  output logic       slave_en_o,
  output logic       wr_en_o
);
  localparam int CNT_W = $clog2(RECOVER_PULSES + 1);
  localparam int IDX_BUS  = 0;
  localparam int IDX_STRM = 1;

  logic [1:0]       rise, fall;
  logic [CNT_W-1:0] cnt;
  logic             full, in_trans;
  mode_e            mode;

  mdx_edge #(.N(2), .RST_VAL(1'b1)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({strm_clk_i, bus_clk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  // Count idle stream pulses only in transition; any bus clock fall restarts.
  mdx_pulse_cnt #(.LIMIT(RECOVER_PULSES), .W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (fall[IDX_BUS] || !in_trans),
    .inc_i  (rise[IDX_STRM] && bus_clk_i),
    .cnt_o  (cnt),
    .full_o (full)
  );

  mdx_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .bus_fall_i  (fall[IDX_BUS]),
    .hit_i       (addr_hit_i),
    .full_i      (full),
    .strm_lvl_i  (strm_clk_i),
    .mode_o      (mode),
    .in_trans_o  (in_trans),
    .stream_en_o (stream_en_o),
    .slave_en_o  (slave_en_o),
    .restart_o   (stream_restart_o),
    .wr_en_o     (wr_en_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/mdx_mode_ctrl_chk.sv
module mdx_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_clk_i,
  input logic       strm_clk_i,
  input logic       addr_hit_i,
  input logic [1:0] mode_o,
  input logic       stream_en_o,
  input logic       stream_restart_o,
  input logic       slave_en_o,
  input logic       wr_en_o
);
  a_r1_reset_stream: assert property (@(posedge clk)
    rst |=> (mode_o == 2'b00 && stream_en_o && !slave_en_o && !wr_en_o));

  a_r2_enter_trans: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && !$past(rst) && $past(bus_clk_i) && !bus_clk_i) |=> mode_o == 2'b01);

  a_r4_restart_on_return: assert property (@(posedge clk) disable iff (rst)
    stream_restart_o |-> (mode_o == 2'b00 && $past(mode_o) == 2'b01));

  a_r4_restart_single: assert property (@(posedge clk) disable iff (rst)
    stream_restart_o |=> !stream_restart_o);

  a_r7_hit_locks: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && addr_hit_i) |=> mode_o == 2'b10);

  a_r8_bidir_sticky: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'b10 |=> mode_o == 2'b10);

  a_r9_hit_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && addr_hit_i && !($past(bus_clk_i) && !bus_clk_i)) |=> mode_o == 2'b00);

  a_r10_wr_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wr_en_o == (mode_o == 2'b10 && $past(strm_clk_i))));

  a_r2_legal_mode: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b11);
endmodule

bind mdx_mode_ctrl mdx_mode_ctrl_chk chk_i (
  .clk              (clk),
  .rst              (rst),
  .bus_clk_i        (bus_clk_i),
  .strm_clk_i       (strm_clk_i),
  .addr_hit_i       (addr_hit_i),
  .mode_o           (mode_o),
  .stream_en_o      (stream_en_o),
  .stream_restart_o (stream_restart_o),
  .slave_en_o       (slave_en_o),
  .wr_en_o          (wr_en_o)
);

// File: tb/mdx_mode_ctrl_tb.sv
`timescale 1ns/1ps
module mdx_mode_ctrl_tb_top;
  localparam int PULSES = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_clk = 1'b1, strm_clk = 1'b0, hit = 1'b0;
  logic [1:0] mode;
  logic sen, rs, slv, wr;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit armed = 0;

  always #2.5 clk = ~clk;

  mdx_mode_ctrl #(.RECOVER_PULSES(PULSES)) dut_i (
    .clk (clk), .rst (rst), .bus_clk_i (bus_clk), .strm_clk_i (strm_clk),
    .addr_hit_i (hit), .mode_o (mode), .stream_en_o (sen),
    .stream_restart_o (rs), .slave_en_o (slv), .wr_en_o (wr)
  );

  // Behavioural reference model
  int m_mode = 0, m_cnt = 0;
  bit m_bus_p = 1, m_strm_p = 1, m_rs = 0, m_wr = 0;

  always @(posedge clk) begin
    bit f, r;
    armed <= 1;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_bus_p = 1; m_strm_p = 1; m_rs = 0; m_wr = 0;
    end else begin
      f = m_bus_p && !bus_clk;
      r = !m_strm_p && strm_clk;
      m_rs = 0;
      if (m_mode == 0) begin
        if (f) begin m_mode = 1; m_cnt = 0; end
      end else if (m_mode == 1) begin
        if (hit) m_mode = 2;
        else if (f) m_cnt = 0;
        else if (m_cnt >= PULSES) begin m_mode = 0; m_rs = 1; m_cnt = 0; end
        else if (r && bus_clk) m_cnt++;
      end
      m_wr = (m_mode == 2) && strm_clk;
      m_bus_p = bus_clk; m_strm_p = strm_clk;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk({cur_req, " model mode"},    mode, m_mode);
    chk({cur_req, " model sen"},     sen,  m_mode == 0);
    chk({cur_req, " model slv"},     slv,  m_mode != 0);
    chk({cur_req, " model restart"}, rs,   m_rs);
    chk({cur_req, " model wr"},      wr,   m_wr);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic vpulse(int n);
    for (int i = 0; i < n; i++) begin
      strm_clk = 1; cyc(); strm_clk = 0; cyc();
    end
  endtask

  task automatic bus_fall_rise();
    bus_clk = 0; cyc(); bus_clk = 1; cyc();
  endtask

  task automatic do_reset();
    rst = 1; cyc(2); rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("R1 reset mode", mode, 0); chk("R1 reset sen", sen, 1);
    chk("R1 reset slv", slv, 0);   chk("R1 reset wr", wr, 0);
    rst = 0; cyc();
    chk("R1 first cycle mode", mode, 0); chk("R1 first cycle restart", rs, 0);

    cur_req = "R9";
    hit = 1; cyc(); hit = 0; vpulse(3);
    chk("R9 hit in stream mode", mode, 0); chk("R9 slave stays off", slv, 0);

    cur_req = "R2";
    bus_clk = 0; cyc();
    chk("R2 trans after fall", mode, 1); chk("R2 stream released", sen, 0);
    chk("R2 slave enabled", slv, 1);
    bus_clk = 1; cyc();

    cur_req = "R5";
    vpulse(PULSES - 1);
    bus_fall_rise();
    vpulse(PULSES - 1);
    chk("R5 count cleared by fall", mode, 1);

    cur_req = "R3";
    strm_clk = 1; cyc();
    chk("R3 still trans at full count", mode, 1); chk("R4 no early restart", rs, 0);
    strm_clk = 0; cyc();
    chk("R3 back to stream", mode, 0); chk("R3 stream enabled", sen, 1);
    chk("R4 restart pulse", rs, 1);
    cyc();
    chk("R4 restart one cycle", rs, 0);

    cur_req = "R6";
    bus_clk = 0; cyc();
    chk("R6 trans entered", mode, 1);
    vpulse(100);
    bus_clk = 1; cyc();
    vpulse(PULSES - 1);
    chk("R6 low-bus pulses not counted", mode, 1);
    vpulse(1); cyc();
    chk("R6 recovery after idle pulses", mode, 0);

    cur_req = "R7";
    bus_fall_rise();
    vpulse(PULSES - 1);
    strm_clk = 1; cyc(); strm_clk = 0; hit = 1; cyc(); hit = 0;
    chk("R7 hit wins over full count", mode, 2);
    chk("R4 no restart when locking", rs, 0);

    cur_req = "R8";
    for (int i = 0; i < 3; i++) bus_fall_rise();
    hit = 1; cyc(); hit = 0;
    vpulse(PULSES + 20);
    chk("R8 bidir sticky", mode, 2); chk("R8 stream off", sen, 0);

    cur_req = "R10";
    strm_clk = 1; cyc();
    chk("R10 wr follows high", wr, 1);
    strm_clk = 0; cyc();
    chk("R10 wr follows low", wr, 0);
    strm_clk = 1; cyc(2);

    cur_req = "R8";
    do_reset(); cyc();
    chk("R8 reset leaves bidir", mode, 0);
    chk("R10 wr low outside bidir", wr, 0);

    cur_req = "R7";
    bus_clk = 0; cyc(); bus_clk = 1; cyc();
    bus_clk = 0; hit = 1; cyc(); hit = 0; bus_clk = 1;
    chk("R7 hit wins over fall", mode, 2);
    cyc(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule